// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Refresh Sweep

This block turns a simple synchronous request port into the strobe sequences of an asynchronous DRAM organised as 2048 rows by 2048 columns. A requester presents a 22-bit word address, a read/write flag and write data, and holds them until the controller answers with a one-clock ready pulse. For a read, the captured data comes back in that same cycle. The upper half of the address picks the row and the lower half picks the column. Both halves share one set of 11 address pins, and the row goes out first.

Every analog interval is a clock-cycle count set by a parameter. These cover the row cycle, the minimum time the row strobe stays active, precharge, the row-to-column delay, the access time from each strobe, and the column cycle. The controller leaves a row open after an access, so later accesses to that row need only a column strobe. A request to a different row, or a refresh that falls due, closes the row first. A free-running interval timer asks for one row-only refresh cycle per slot and walks an 11-bit row counter through the whole array.

Top module: `dram_ctl`

## Requirements
- R1: While reset is held, the row, column and write strobes are high (inactive), the data output enable is low and ready is low.
- R2: The row half `req_addr[21:11]` is on `mem_addr` when the row strobe falls, and the column half `req_addr[10:0]` is on `mem_addr` when the column strobe falls. The column strobe is only low while the row strobe is low, and `mem_addr` stays stable while the column strobe is low.
- R3: Successive row-strobe falls are at least ROWCYC cycles apart. The row strobe stays low for at least ROWACT_MIN cycles and stays high for at least PRECHG cycles before it falls again.
- R4: Read data is sampled no earlier than ROW_ACC cycles after the row strobe fell and no earlier than COL_ACC cycles after the column strobe fell. It is returned on `rsp_rdata` in the ready cycle.
- R5: Successive column-strobe falls are at least COL_CYC cycles apart.
- R6: Consecutive accesses to the row that is already open reuse it without a new row-strobe cycle, unless a refresh intervenes.
- R7: An access to a row other than the open one closes the row and opens the new one, so every access in an alternating-row stream opens a row.
- R8: For a write, the write strobe goes low at least one cycle before the column strobe falls. The data output enable is high exactly while the write strobe is low. Reads keep the write strobe high.
- R9: Each request gets exactly one ready pulse, one cycle wide.
- R10: Refresh cycles run with the column strobe held high. Their rows count up by one from 0 and wrap from 2047 back to 0. Successive refresh cycles start no more than REF_GAP plus 40 cycles apart.
- R11: A pending refresh takes the open row away from a waiting same-row request once the current access has finished, so a long same-row stream still sees refreshes at the configured rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present; held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in the upper 11 bits |
| req_wdata | input | DQ_W | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DQ_W | Read data, valid with ready |
| mem_addr | output | 11 | Shared row/column address pins |
| row_stb_n | output | 1 | Row strobe, active low |
| col_stb_n | output | 1 | Column strobe, active low |
| wr_en_n | output | 1 | Write strobe, active low |
| mem_dout_en | output | 1 | Data output enable (writes only) |
| mem_dout | output | DQ_W | Data to the memory |
| mem_din | input | DQ_W | Data from the memory |

## Verification
The bench memory model drives the inverse of the stored data until both access windows have elapsed. A controller that samples even one cycle early therefore returns corrupted reads, and the scoreboard catches them. The model also measures strobe spacing, active time and precharge time on the pins. A design that mis-sized any interval trips these checks, as does one that swapped the row and column halves or skipped the write-strobe lead. Row-open counts separate a design that reopens the row on every hit from one that keeps a stale row on a miss. An idle sweep past 2048 refreshes catches a row counter that fails to wrap or skips rows, and a long same-row stream catches a refresh starved by page hits.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_OPEN,
    ST_WSETUP,
    ST_COL,
    ST_REFRESH
  } seq_state_e;

  localparam int AGE_ROW = 0;  // since row strobe fell
  localparam int AGE_PRE = 1;  // since row strobe rose
  localparam int AGE_COL = 2;  // since column strobe fell
  localparam int N_AGES  = 3;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_age_timer.sv
module dram_age_timer #(
  parameter int MAX_AGE = 15,
  localparam int AW = $clog2(MAX_AGE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [AW-1:0] age
);

  localparam logic [AW-1:0] SAT = AW'(MAX_AGE);

  logic [AW-1:0] age_d;

  always_comb begin
    if (restart)          age_d = '0;
    else if (age != SAT)  age_d = age + 1'b1;
    else                  age_d = age;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= SAT;
    else        age <= age_d;
  end

endmodule

// File: rtl/dram_refresh.sv
module dram_refresh #(
  parameter int REF_GAP = 3906,
  parameter int ROW_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_done,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);

  localparam int CW = $clog2(REF_GAP + 1);
  localparam logic [CW-1:0] LAST = CW'(REF_GAP - 1);

  logic [CW-1:0]    slot_q, slot_d;
  logic             tick;
  logic             pend_d;
  logic [ROW_W-1:0] row_d;

  always_comb begin
    tick   = (slot_q == LAST);
    slot_d = tick ? '0 : slot_q + 1'b1;
    pend_d = tick | (ref_pend & ~ref_done);
    row_d  = ref_done ? ref_row + 1'b1 : ref_row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      slot_q   <= slot_d;
      ref_pend <= pend_d;
      if (ref_done) ref_row <= row_d;
    end
  end

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctl_pkg::*;
#(
  parameter int ROW_W      = 11,
  parameter int DQ_W       = 1,
  parameter int AW         = 4,
  parameter int ROWCYC     = 14,
  parameter int ROWACT_MIN = 8,
  parameter int PRECHG     = 6,
  parameter int ROW2COL    = 3,
  parameter int ROW_ACC    = 8,
  parameter int COL_ACC    = 2,
  parameter int COL_CYC    = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ROW_W-1:0]         req_row,
  input  logic [ROW_W-1:0]         req_col,
  input  logic [DQ_W-1:0]          req_wdata,
  output logic                     req_ready,
  output logic [DQ_W-1:0]          rsp_rdata,
  input  logic                     ref_pend,
  input  logic [ROW_W-1:0]         ref_row,
  output logic                     ref_done,
  input  logic [N_AGES-1:0][AW-1:0] ages,
  output logic [N_AGES-1:0]        restart,
  output logic [ROW_W-1:0]         mem_addr,
  output logic                     row_stb_n,
  output logic                     col_stb_n,
  output logic                     wr_en_n,
  output logic                     mem_dout_en,
  output logic [DQ_W-1:0]          mem_dout,
  input  logic [DQ_W-1:0]          mem_din
);

  localparam logic [AW-1:0] LIM_RC  = AW'(ROWCYC - 1);
  localparam logic [AW-1:0] LIM_ACT = AW'(ROWACT_MIN - 1);
  localparam logic [AW-1:0] LIM_PRE = AW'(PRECHG - 1);
  localparam logic [AW-1:0] LIM_RCD = AW'(ROW2COL - 1);
  localparam logic [AW-1:0] LIM_RAC = AW'(ROW_ACC - 1);
  localparam logic [AW-1:0] LIM_CAC = AW'(COL_ACC - 1);
  localparam logic [AW-1:0] LIM_PC  = AW'(COL_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [ROW_W-1:0] row_q, col_q;
  logic             wr_q;
  logic [DQ_W-1:0]  wdata_q, rdata_q;
  logic             rdy_q;

  logic start_ok, act_ok, rcd_ok, page_ok, cac_ok, rac_ok;
  logic row_hit, col_done, row_ld, col_ld, rd_cap;

  always_comb begin
    start_ok = (ages[AGE_ROW] >= LIM_RC) && (ages[AGE_PRE] >= LIM_PRE);
    act_ok   = ages[AGE_ROW] >= LIM_ACT;
    rcd_ok   = ages[AGE_ROW] >= LIM_RCD;
    rac_ok   = ages[AGE_ROW] >= LIM_RAC;
    cac_ok   = ages[AGE_COL] >= LIM_CAC;
    page_ok  = ages[AGE_COL] >= LIM_PC;
    row_hit  = (req_row == row_q);
    col_done = cac_ok && (wr_q || rac_ok);
  end

  // next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          if (ref_pend)       state_d = ST_REFRESH;
          else if (req_valid) state_d = ST_ROW;
        end
      end
      ST_ROW:    if (rcd_ok) state_d = req_write ? ST_WSETUP : ST_COL;
      ST_OPEN: begin
        if (ref_pend || (req_valid && !row_hit)) begin
          if (act_ok) state_d = ST_IDLE;
        end else if (req_valid && page_ok) begin
          state_d = req_write ? ST_WSETUP : ST_COL;
        end
      end
      ST_WSETUP:  state_d = ST_COL;
      ST_COL:     if (col_done) state_d = ST_OPEN;
      ST_REFRESH: if (act_ok) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    row_ld   = (state_q == ST_IDLE) && (state_d == ST_ROW);
    col_ld   = ((state_d == ST_WSETUP) || (state_d == ST_COL)) &&
               ((state_q == ST_ROW) || (state_q == ST_OPEN));
    rd_cap   = (state_q == ST_COL) && col_done && !wr_q;
    ref_done = (state_q == ST_REFRESH) && act_ok;
    restart[AGE_ROW] = (state_q == ST_IDLE) &&
                       ((state_d == ST_ROW) || (state_d == ST_REFRESH));
    restart[AGE_PRE] = (state_q != ST_IDLE) && (state_d == ST_IDLE);
    restart[AGE_COL] = (state_q != ST_COL) && (state_d == ST_COL);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rdy_q   <= (state_q == ST_COL) && col_done;
      if (row_ld) row_q <= req_row;
      if (col_ld) begin
        col_q   <= req_col;
        wr_q    <= req_write;
        wdata_q <= req_wdata;
      end
      if (rd_cap) rdata_q <= mem_din;
    end
  end

  // pin decode
  always_comb begin
    unique case (state_q)
      ST_ROW:     mem_addr = row_q;
      ST_REFRESH: mem_addr = ref_row;
      default:    mem_addr = col_q;
    endcase
    row_stb_n   = (state_q == ST_IDLE);
    col_stb_n   = (state_q != ST_COL);
    wr_en_n     = !((state_q == ST_WSETUP) || ((state_q == ST_COL) && wr_q));
    mem_dout_en = !wr_en_n;
    mem_dout    = wdata_q;
    req_ready   = rdy_q;
    rsp_rdata   = rdata_q;
  end

endmodule

// File: rtl/dram_ctl.sv
module dram_ctl
  import dram_ctl_pkg::*;
#(
  parameter int ROW_W      = 11,
  parameter int DQ_W       = 1,
  parameter int ROWCYC     = 14,
  parameter int ROWACT_MIN = 8,
  parameter int PRECHG     = 6,
  parameter int ROW2COL    = 3,
  parameter int ROW_ACC    = 8,
  parameter int COL_ACC    = 2,
  parameter int COL_CYC    = 5,
  parameter int REF_GAP    = 3906,
  localparam int ADDR_W    = 2 * ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              req_ready,
  output logic [DQ_W-1:0]   rsp_rdata,
  output logic [ROW_W-1:0]  mem_addr,
  output logic              row_stb_n,
  output logic              col_stb_n,
  output logic              wr_en_n,
  output logic              mem_dout_en,
  output logic [DQ_W-1:0]   mem_dout,
  input  logic [DQ_W-1:0]   mem_din
);

  localparam int AGE_MAX = imax(imax(imax(ROWCYC, ROWACT_MIN), imax(PRECHG, ROW2COL)),
                                imax(imax(ROW_ACC, COL_ACC), COL_CYC));
  localparam int AW = $clog2(AGE_MAX + 1);

  logic [1:0]                sync_q;
  logic                      srst_n;
  logic [N_AGES-1:0]         restart;
  logic [N_AGES-1:0][AW-1:0] ages;
  logic                      ref_pend, ref_done;
  logic [ROW_W-1:0]          ref_row;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign srst_n = sync_q[1];

  for (genvar g = 0; g < N_AGES; g++) begin : g_age
    dram_age_timer #(.MAX_AGE(AGE_MAX)) u_age (
      .clk     (clk),
      .rst_n   (srst_n),
      .restart (restart[g]),
      .age     (ages[g])
    );
  end

  dram_refresh #(.REF_GAP(REF_GAP), .ROW_W(ROW_W)) u_refresh (
    .clk      (clk),
    .rst_n    (srst_n),
    .ref_done (ref_done),
    .ref_pend (ref_pend),
    .ref_row  (ref_row)
  );

  dram_seq #(
    .ROW_W(ROW_W), .DQ_W(DQ_W), .AW(AW),
    .ROWCYC(ROWCYC), .ROWACT_MIN(ROWACT_MIN), .PRECHG(PRECHG),
    .ROW2COL(ROW2COL), .ROW_ACC(ROW_ACC), .COL_ACC(COL_ACC), .COL_CYC(COL_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (srst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_row     (req_addr[ADDR_W-1 -: ROW_W]),
    .req_col     (req_addr[ROW_W-1:0]),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .rsp_rdata   (rsp_rdata),
    .ref_pend    (ref_pend),
    .ref_row     (ref_row),
    .ref_done    (ref_done),
    .ages        (ages),
    .restart     (restart),
    .mem_addr    (mem_addr),
    .row_stb_n   (row_stb_n),
    .col_stb_n   (col_stb_n),
    .wr_en_n     (wr_en_n),
    .mem_dout_en (mem_dout_en),
    .mem_dout    (mem_dout),
    .mem_din     (mem_din)
  );

endmodule

// File: rtl/dram_ctl_chk.sv
module dram_ctl_chk #(
  parameter int ROW_W   = 11,
  parameter int ROWCYC  = 14,
  parameter int COL_CYC = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             row_stb_n,
  input logic             col_stb_n,
  input logic             wr_en_n,
  input logic             mem_dout_en,
  input logic             req_ready,
  input logic [ROW_W-1:0] mem_addr
);

  localparam int GMAX_I = ((ROWCYC > COL_CYC) ? ROWCYC : COL_CYC) + 1;
  localparam int GW = $clog2(GMAX_I + 1);
  localparam logic [GW-1:0] GMAX   = GW'(GMAX_I);
  localparam logic [GW-1:0] RC_MIN = GW'(ROWCYC - 1);
  localparam logic [GW-1:0] PC_MIN = GW'(COL_CYC - 1);

  logic          row_prev, col_prev;
  logic [GW-1:0] row_gap, col_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_prev <= 1'b1;
      col_prev <= 1'b1;
      row_gap  <= GMAX;
      col_gap  <= GMAX;
    end else begin
      row_prev <= row_stb_n;
      col_prev <= col_stb_n;
      if (!row_stb_n && row_prev) row_gap <= '0;
      else if (row_gap != GMAX)   row_gap <= row_gap + 1'b1;
      if (!col_stb_n && col_prev) col_gap <= '0;
      else if (col_gap != GMAX)   col_gap <= col_gap + 1'b1;
    end
  end

  // R2
  col_under_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !col_stb_n |-> !row_stb_n);

  // R2
  col_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_stb_n && !col_prev) |-> $stable(mem_addr));

  // R3
  row_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_stb_n && row_prev) |-> (row_gap >= RC_MIN));

  // R5
  col_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_stb_n && col_prev) |-> (col_gap >= PC_MIN));

  // R8
  oe_tracks_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en == !wr_en_n);

  // R8
  we_leads_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_stb_n && col_prev && !wr_en_n) |-> $past(!wr_en_n));

  // R9
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

endmodule

bind dram_ctl dram_ctl_chk #(
  .ROW_W(ROW_W), .ROWCYC(ROWCYC), .COL_CYC(COL_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .row_stb_n   (row_stb_n),
  .col_stb_n   (col_stb_n),
  .wr_en_n     (wr_en_n),
  .mem_dout_en (mem_dout_en),
  .req_ready   (req_ready),
  .mem_addr    (mem_addr)
);

// File: tb/dram_ctl_bench.sv
`timescale 1ns/1ps
module dram_ctl_bench;

  localparam int DQ_W = 4, ROW_W = 11;
  localparam int ROWCYC = 14, ROWACT_MIN = 8, PRECHG = 6, ROW2COL = 3;
  localparam int ROW_ACC = 8, COL_ACC = 2, COL_CYC = 5, REF_GAP = 40;
  localparam int SLACK = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [DQ_W-1:0] req_wdata = '0;
  logic req_ready;
  logic [DQ_W-1:0] rsp_rdata, mem_dout, mem_din = '0;
  logic [ROW_W-1:0] mem_addr;
  logic row_stb_n, col_stb_n, wr_en_n, mem_dout_en;

  always #4 clk = ~clk;

  dram_ctl #(
    .ROW_W(ROW_W), .DQ_W(DQ_W), .ROWCYC(ROWCYC), .ROWACT_MIN(ROWACT_MIN),
    .PRECHG(PRECHG), .ROW2COL(ROW2COL), .ROW_ACC(ROW_ACC), .COL_ACC(COL_ACC),
    .COL_CYC(COL_CYC), .REF_GAP(REF_GAP)
  ) u_dram_ctl (.*);

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- memory model ----------------
  logic [DQ_W-1:0] dmem [int];
  logic [DQ_W-1:0] shadow [int];
  logic [21:0] cur_addr = '0;
  bit cur_wr = 0;
  logic row_prev = 1, col_prev = 1, we_prev = 1;
  logic [ROW_W-1:0] m_row = '0;
  int mr = 0, mc = 0;
  int last_fall = -1000, last_rise = -1000, fall_cyc = 0, last_ref_fall = -1;
  bit saw_col = 0;
  int opens = 0, refs = 0;
  logic [ROW_W-1:0] exp_ref = '0;

  function automatic logic [DQ_W-1:0] mrd(input int a);
    return dmem.exists(a) ? dmem[a] : '0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    row_prev <= row_stb_n; col_prev <= col_stb_n; we_prev <= wr_en_n;
    mr <= row_stb_n ? 0 : mr + 1;
    mc <= col_stb_n ? 0 : mc + 1;
    if (rst_n) begin
      if (!row_stb_n && row_prev) begin
        chk(cyc - last_fall >= ROWCYC, "R3 row cycle", cyc - last_fall, ROWCYC);
        chk(cyc - last_rise >= PRECHG, "R3 precharge", cyc - last_rise, PRECHG);
        m_row <= mem_addr; last_fall <= cyc; fall_cyc <= cyc; saw_col <= 0;
      end
      if (row_stb_n && !row_prev) begin
        chk(cyc - last_fall >= ROWACT_MIN, "R3 active time", cyc - last_fall, ROWACT_MIN);
        last_rise <= cyc;
        if (!saw_col) begin
          chk(m_row == exp_ref, "R10 refresh row", m_row, exp_ref);
          if (last_ref_fall >= 0)
            chk(fall_cyc - last_ref_fall <= REF_GAP + SLACK, "R10 refresh spacing",
                fall_cyc - last_ref_fall, REF_GAP + SLACK);
          last_ref_fall <= fall_cyc; exp_ref <= exp_ref + 1'b1; refs <= refs + 1;
        end
      end
      if (!col_stb_n && col_prev) begin
        chk({m_row, mem_addr} == cur_addr, "R2 address halves", {m_row, mem_addr}, cur_addr);
        chk(wr_en_n == !cur_wr, "R8 write strobe level", wr_en_n, !cur_wr);
        if (!wr_en_n) begin
          chk(!we_prev && mem_dout_en, "R8 write strobe lead", we_prev, 0);
          dmem[int'({m_row, mem_addr})] = mem_dout;
        end
        if (!saw_col) opens <= opens + 1;
        saw_col <= 1;
      end
    end
  end

  // data is valid only once both access windows have run out
  always @(negedge clk) begin
    if (!col_stb_n && mr >= ROW_ACC - 1 && mc >= COL_ACC - 1)
      mem_din <= mrd(int'({m_row, mem_addr}));
    else
      mem_din <= ~mrd(int'({m_row, mem_addr}));
  end

  // ---------------- scoreboard ----------------
  bit exp_wr[$];
  logic [DQ_W-1:0] exp_dat[$];

  always @(negedge clk) begin
    if (rst_n && req_ready) begin
      if (exp_wr.size() == 0) chk(0, "R9 ready without request", 1, 0);
      else begin
        bit w;
        logic [DQ_W-1:0] d;
        w = exp_wr.pop_front(); d = exp_dat.pop_front();
        if (!w) chk(rsp_rdata == d, "R4 read data", rsp_rdata, d);
      end
    end
  end

  task automatic do_req(input bit wr, input logic [21:0] a, input logic [DQ_W-1:0] d);
    @(negedge clk);
    cur_addr = a; cur_wr = wr;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    exp_wr.push_back(wr);
    if (wr) begin shadow[int'(a)] = d; exp_dat.push_back(d); end
    else exp_dat.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : '0);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    req_valid = 0;
  endtask

  function automatic logic [21:0] mk(input int r, input int c);
    return {r[10:0], c[10:0]};
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // ---------------- stimulus ----------------
  int rows[8] = '{5, 5, 5, 900, 900, 2047, 0, 1234};
  int cols[8] = '{0, 1, 2047, 17, 18, 2047, 0, 600};

  initial begin
    int o0, r0, t0;
    repeat (3) @(negedge clk);
    // R1
    chk(row_stb_n && col_stb_n && wr_en_n, "R1 strobes idle in reset",
        {row_stb_n, col_stb_n, wr_en_n}, 7);
    chk(!mem_dout_en && !req_ready, "R1 enable and ready low in reset",
        {mem_dout_en, req_ready}, 0);
    @(posedge clk); rst_n = 1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 8; i++) do_req(1, mk(rows[i], cols[i]), DQ_W'(i * 3 + 5));
    for (int i = 7; i >= 0; i--) do_req(0, mk(rows[i], cols[i]), '0);

    // R6: page hits
    o0 = opens; r0 = refs;
    for (int i = 0; i < 6; i++) do_req(i % 2, mk(77, i * 9), DQ_W'(i + 1));
    @(negedge clk);
    chk(opens - o0 <= 1 + (refs - r0), "R6 row reuse", opens - o0, 1 + (refs - r0));

    // R7: alternating rows
    o0 = opens;
    for (int i = 0; i < 6; i++) do_req(0, mk(10 + i % 2, 3), '0);
    chk(opens - o0 == 6, "R7 row reopen on miss", opens - o0, 6);

    // R11: long same-row stream must not starve refresh
    r0 = refs; t0 = cyc;
    for (int i = 0; i < 40; i++) do_req(0, mk(5, i % 3), '0);
    chk(refs - r0 >= (cyc - t0) / REF_GAP - 1, "R11 refresh during page stream",
        refs - r0, (cyc - t0) / REF_GAP - 1);

    // R10: full sweep and wrap of the refresh row
    repeat (2048 * REF_GAP + 300) @(negedge clk);
    chk(refs >= 2049, "R10 refresh row wrap", refs, 2049);

    for (int i = 0; i < 8; i++) do_req(0, mk(rows[i], cols[i]), '0);
    repeat (4) @(negedge clk);
    // R9
    chk(exp_wr.size() == 0, "R9 one ready per request", exp_wr.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule